// File: doc/BRIEF.md
# Nibble-Packed Tag Check Engine

This engine checks one memory access of any length against the allocation tags kept in a separate tag store. The caller gives the access start address, the access size minus one, and two per-half enables. The logical tag is carried in the pointer's upper bits. Each tag covers a 16-byte granule. The store packs two 4-bit tags into every byte, with the lower granule's tag in the low nibble. The engine walks the tag bytes covered by the access. It reads one byte per cycle through a synchronous read port whose data returns one cycle after the request. It compares every covered nibble with the logical tag and stops at the first mismatch.

When the walk ends, a one-cycle done pulse carries a pass flag and, on a mismatch, a fault address. If the mismatch is in the first granule of the access, the fault address is the access start address. For any later granule it is the base address of that granule. Some accesses are passed at once, without any tag read: those whose selected half has checking disabled, and those made while the page-has-no-tags input is set. The engine accepts a request only while idle. It assumes the access stays inside one 4 KiB page.

Top module: `tag_check_engine`

## Requirements
- R1: After reset the engine is idle: `idle` is 1, and `done` and `tagRdEn` are 0.
- R2: Address bit 55 picks the enable: bit 55 = 0 uses `tbiEnable[0]` and bit 55 = 1 uses `tbiEnable[1]`. When the picked enable is 0, the access passes with no tag read. `done` is high in the cycle after acceptance, with `pass` = 1.
- R3: When `untaggedPage` is 1 at acceptance, the access passes with no tag read. `done` is high in the cycle after acceptance.
- R4: For a checked access, the first tag read address is start >> 5, and each later read in the same request is one higher. The engine makes at most one read per cycle. A passing access makes exactly ((align32(start+sizeM1) − align32(start)) / 32) + 1 reads, one in each of that many consecutive cycles.
- R5: In a tag byte, bits [3:0] hold the tag of the granule whose address bit 4 is 0, and bits [7:4] hold the tag of the granule whose address bit 4 is 1.
- R6: Exactly ((align16(start+sizeM1) − align16(start)) / 16) + 1 tags are compared. A nibble of the last byte outside the access is ignored.
- R7: When start address bit 4 is 1, the low nibble of the first byte is ignored.
- R8: A mismatch in the first granule (index 0) reports the start address itself as `faultAddr`, with `pass` = 0.
- R9: A mismatch at granule index n > 0 reports align16(start) + 16·n as `faultAddr`.
- R10: When several granules mismatch, the lowest-index granule is reported.
- R11: While a request is in progress (`idle` = 0), `reqValid` is ignored. The result belongs to the first request, and no second result follows.
- R12: The logical tag is pointer bits [59:56].
- R13: `done` lasts exactly one cycle. For a passing checked access that reads B bytes, `done` rises B + 2 cycles after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken when `idle` is 1 |
| reqAddr | input | ADDR_W | Access start pointer, including the logical tag in [59:56] |
| reqSizeM1 | input | SIZE_W | Access length in bytes minus one |
| tbiEnable | input | 2 | Check enable for the lower [0] and upper [1] address half |
| untaggedPage | input | 1 | Page has no tag storage: pass without reading |
| idle | output | 1 | Engine can accept a request |
| tagRdEn | output | 1 | Tag byte read request |
| tagRdAddr | output | ADDR_W-5 | Tag byte address |
| tagRdData | input | 8 | Tag byte, valid the cycle after `tagRdEn` |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Check result, valid with `done` |
| faultAddr | output | ADDR_W | First failing address, valid with `done` when `pass` is 0 |

## Verification
The bench aims at the nibble edges of an access. One case starts on an odd granule, where a design that checked the low nibble would report a false mismatch. Another ends on an even granule, where a design that checked the trailing high nibble would fail a clean access. Fault addresses are checked in both the first and a later granule. A design that always used the granule base would lose the byte offset of the start, and one that always used the start would report the wrong granule. Accesses with two mismatches show whether the walk stops at the earliest one. Enable-selection, no-tag-page and busy-time requests expose a design that reads when it should not, picks the wrong enable by bit 55, or lets a second request disturb the result.

// File: rtl/tce_pkg.sv
package tce_pkg;
  localparam int GRAN_LOG2    = 4;
  localparam int PAIR_LOG2    = 5;
  localparam int PTR_TAG_LSB  = 56;
  localparam int TAG_W        = 4;
  localparam int HALF_SEL_BIT = 55;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } tceState_t;

  typedef struct packed {
    logic load;
    logic issue;
    logic consume;
    logic latchPass;
    logic latchFail;
  } tceStrobes_t;
endpackage

// File: rtl/tce_nib_cmp.sv
module tce_nib_cmp import tce_pkg::*; (
  input  logic [2*TAG_W-1:0] tagByte,
  input  logic [TAG_W-1:0]   logTag,
  output logic [1:0]         nibMis
);
  for (genvar gi = 0; gi < 2; gi++) begin : g_nib
    assign nibMis[gi] = tagByte[gi*TAG_W +: TAG_W] != logTag;
  end
endmodule

// File: rtl/tce_ctrl.sv
module tce_ctrl import tce_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqHalfSel,
  input  logic [1:0]  tbiEnable,
  input  logic        untaggedPage,
  input  logic        bytesPending,
  input  logic        dataValid,
  input  logic        hitFail,
  input  logic        lastCompare,
  output tceStrobes_t strobes,
  output logic        idle,
  output logic        done,
  output logic        tagRdEn
);
  tceState_t state, nextState;
  logic bypass;

  assign bypass = untaggedPage || !tbiEnable[reqHalfSel];

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.load = 1'b1;
          if (bypass) begin
            strobes.latchPass = 1'b1;
            nextState = ST_DONE;
          end else begin
            nextState = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        strobes.issue = bytesPending;
        if (dataValid) begin
          strobes.consume = 1'b1;
          if (hitFail) begin
            strobes.latchFail = 1'b1;
            nextState = ST_DONE;
          end else if (lastCompare) begin
            strobes.latchPass = 1'b1;
            nextState = ST_DONE;
          end
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign idle    = state == ST_IDLE;
  assign done    = state == ST_DONE;
  assign tagRdEn = strobes.issue;
endmodule

// File: rtl/tce_datapath.sv
module tce_datapath import tce_pkg::*; #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tceStrobes_t               strobes,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [SIZE_W-1:0]         reqSizeM1,
  input  logic [2*TAG_W-1:0]        tagRdData,
  output logic [ADDR_W-PAIR_LOG2-1:0] tagRdAddr,
  output logic                      bytesPending,
  output logic                      dataValid,
  output logic                      hitFail,
  output logic                      lastCompare,
  output logic                      pass,
  output logic [ADDR_W-1:0]         faultAddr
);
  localparam int RD_W  = ADDR_W - PAIR_LOG2;
  localparam int CNT_W = SIZE_W - GRAN_LOG2 + 1;

  logic [ADDR_W-1:0] startAddr, faultQ, lastAddr, baseAddr, failAddr;
  logic [TAG_W-1:0]  logTag;
  logic [RD_W-1:0]   rdAddrQ;
  logic [CNT_W-1:0]  bytesLeft, tagsLeft, granIdx;
  logic [CNT_W-1:0]  tagCountIn, byteCountIn, remAfterLo, nChecked, failIdx;
  logic              firstByte, oddStart, dataValidQ, passQ;
  logic              checkLo, checkHi, loFail, hiFail;
  logic [1:0]        nibMis;

  // Request geometry
  assign lastAddr    = reqAddr + ADDR_W'(reqSizeM1);
  assign tagCountIn  = CNT_W'((lastAddr >> GRAN_LOG2) - (reqAddr >> GRAN_LOG2)) + CNT_W'(1);
  assign byteCountIn = CNT_W'((lastAddr >> PAIR_LOG2) - (reqAddr >> PAIR_LOG2)) + CNT_W'(1);

  tce_nib_cmp u_cmp (
    .tagByte(tagRdData),
    .logTag (logTag),
    .nibMis (nibMis)
  );

  // Nibble selection for the byte under compare
  assign checkLo     = !(firstByte && oddStart);
  assign remAfterLo  = tagsLeft - CNT_W'(checkLo);
  assign checkHi     = remAfterLo != '0;
  assign loFail      = checkLo && nibMis[0];
  assign hiFail      = checkHi && nibMis[1];
  assign hitFail     = loFail || hiFail;
  assign nChecked    = CNT_W'(checkLo) + CNT_W'(checkHi);
  assign lastCompare = (tagsLeft - nChecked) == '0;

  // Fault address
  assign failIdx  = loFail ? granIdx : granIdx + CNT_W'(checkLo);
  assign baseAddr = {startAddr[ADDR_W-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}};
  assign failAddr = (failIdx == '0) ? startAddr
                                    : baseAddr + (ADDR_W'(failIdx) << GRAN_LOG2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startAddr  <= '0;
      logTag     <= '0;
      rdAddrQ    <= '0;
      bytesLeft  <= '0;
      tagsLeft   <= '0;
      granIdx    <= '0;
      firstByte  <= 1'b0;
      oddStart   <= 1'b0;
      dataValidQ <= 1'b0;
      passQ      <= 1'b0;
      faultQ     <= '0;
    end else begin
      dataValidQ <= strobes.issue;
      if (strobes.load) begin
        startAddr <= reqAddr;
        logTag    <= reqAddr[PTR_TAG_LSB +: TAG_W];
        rdAddrQ   <= reqAddr[ADDR_W-1:PAIR_LOG2];
        bytesLeft <= byteCountIn;
        tagsLeft  <= tagCountIn;
        granIdx   <= '0;
        firstByte <= 1'b1;
        oddStart  <= reqAddr[GRAN_LOG2];
      end
      if (strobes.issue) begin
        rdAddrQ   <= rdAddrQ + RD_W'(1);
        bytesLeft <= bytesLeft - CNT_W'(1);
      end
      if (strobes.consume) begin
        tagsLeft  <= tagsLeft - nChecked;
        granIdx   <= granIdx + nChecked;
        firstByte <= 1'b0;
      end
      if (strobes.latchPass) begin
        passQ  <= 1'b1;
        faultQ <= '0;
      end else if (strobes.latchFail) begin
        passQ  <= 1'b0;
        faultQ <= failAddr;
      end
    end
  end

  assign tagRdAddr    = rdAddrQ;
  assign bytesPending = bytesLeft != '0;
  assign dataValid    = dataValidQ;
  assign pass         = passQ;
  assign faultAddr    = faultQ;
endmodule

// File: rtl/tag_check_engine.sv
module tag_check_engine import tce_pkg::*; #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [SIZE_W-1:0]           reqSizeM1,
  input  logic [1:0]                  tbiEnable,
  input  logic                        untaggedPage,
  output logic                        idle,
  output logic                        tagRdEn,
  output logic [ADDR_W-PAIR_LOG2-1:0] tagRdAddr,
  input  logic [7:0]                  tagRdData,
  output logic                        done,
  output logic                        pass,
  output logic [ADDR_W-1:0]           faultAddr
);
  tceStrobes_t strobes;
  logic bytesPending, dataValid, hitFail, lastCompare;

  tce_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqHalfSel  (reqAddr[HALF_SEL_BIT]),
    .tbiEnable   (tbiEnable),
    .untaggedPage(untaggedPage),
    .bytesPending(bytesPending),
    .dataValid   (dataValid),
    .hitFail     (hitFail),
    .lastCompare (lastCompare),
    .strobes     (strobes),
    .idle        (idle),
    .done        (done),
    .tagRdEn     (tagRdEn)
  );

  tce_datapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqAddr     (reqAddr),
    .reqSizeM1   (reqSizeM1),
    .tagRdData   (tagRdData),
    .tagRdAddr   (tagRdAddr),
    .bytesPending(bytesPending),
    .dataValid   (dataValid),
    .hitFail     (hitFail),
    .lastCompare (lastCompare),
    .pass        (pass),
    .faultAddr   (faultAddr)
  );
endmodule

// File: rtl/tce_checker.sv
module tce_checker import tce_pkg::*; #(
  parameter int ADDR_W = 64
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        reqValid,
  input logic [ADDR_W-1:0]           reqAddr,
  input logic [1:0]                  tbiEnable,
  input logic                        untaggedPage,
  input logic                        idle,
  input logic                        tagRdEn,
  input logic [ADDR_W-PAIR_LOG2-1:0] tagRdAddr,
  input logic                        done,
  input logic                        pass
);
  // R13: result strobe lasts one cycle
  a_r13_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: reads happen only while a check is running
  a_r4_read_busy: assert property (@(posedge clk) disable iff (!rstN)
    tagRdEn |-> (!idle && !done));

  // R4: back-to-back reads walk upward by one byte
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (tagRdEn && $past(tagRdEn)) |-> tagRdAddr == $past(tagRdAddr) + 1'b1);

  // R2: disabled half passes in the next cycle
  a_r2_bypass_pass: assert property (@(posedge clk) disable iff (!rstN)
    (idle && reqValid && !tbiEnable[reqAddr[HALF_SEL_BIT]]) |=> (done && pass && !tagRdEn));

  // R3: page without tags passes with no read
  a_r3_untagged_noread: assert property (@(posedge clk) disable iff (!rstN)
    (idle && reqValid && untaggedPage) |=> (done && pass && !tagRdEn));

  // R11: engine leaves idle only on a request
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !reqValid) |=> idle);
endmodule

bind tag_check_engine tce_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqAddr     (reqAddr),
  .tbiEnable   (tbiEnable),
  .untaggedPage(untaggedPage),
  .idle        (idle),
  .tagRdEn     (tagRdEn),
  .tagRdAddr   (tagRdAddr),
  .done        (done),
  .pass        (pass)
);

// File: tb/tag_check_engine_tb.sv
module tag_check_engine_tb;
  localparam int ADDR_W = 64;
  localparam int SIZE_W = 12;
  localparam int RD_W   = ADDR_W - 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [SIZE_W-1:0] reqSizeM1 = '0;
  logic [1:0]        tbiEnable = 2'b11;
  logic              untaggedPage = 1'b0;
  logic              idle, tagRdEn, done, pass;
  logic [RD_W-1:0]   tagRdAddr;
  logic [7:0]        tagRdData;
  logic [ADDR_W-1:0] faultAddr;

  tag_check_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSizeM1(reqSizeM1), .tbiEnable(tbiEnable), .untaggedPage(untaggedPage),
    .idle(idle), .tagRdEn(tagRdEn), .tagRdAddr(tagRdAddr), .tagRdData(tagRdData),
    .done(done), .pass(pass), .faultAddr(faultAddr)
  );

  logic [7:0] tagMem [256];
  always_ff @(posedge clk) if (tagRdEn) tagRdData <= tagMem[tagRdAddr[7:0]];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Read monitor, sampled away from the clock edge
  int rdCount = 0;
  int seqErr = 0;
  logic [RD_W-1:0] firstRd, lastRd;
  always @(negedge clk) begin
    if (tagRdEn) begin
      if (rdCount == 0) firstRd = tagRdAddr;
      else if (tagRdAddr != lastRd + 1'b1) seqErr++;
      lastRd = tagRdAddr;
      rdCount++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic void fillTags(input logic [3:0] t);
    for (int i = 0; i < 256; i++) tagMem[i] = {t, t};
  endfunction

  function automatic void setNib(input logic [63:0] g, input logic [3:0] v);
    if (g[4]) tagMem[g[12:5]][7:4] = v;
    else      tagMem[g[12:5]][3:0] = v;
  endfunction

  function automatic logic [63:0] mkAddr(input logic [3:0] t, input bit sel, input logic [12:0] low);
    logic [63:0] a = '0;
    a[59:56] = t;
    a[55]    = sel;
    a[12:0]  = low;
    return a;
  endfunction

  function automatic void refModel(input logic [63:0] a, input int sm1, input logic [1:0] tbi,
                                   input bit unt, output bit ePass, output logic [63:0] eFault,
                                   output int eBytes);
    logic [63:0] last, g0, gl, g;
    logic [7:0] b;
    logic [3:0] nib;
    last   = a + 64'(sm1);
    g0     = a & ~64'hF;
    gl     = last & ~64'hF;
    ePass  = 1'b1;
    eFault = '0;
    eBytes = int'((last >> 5) - (a >> 5)) + 1;
    if (unt || !tbi[a[55]]) begin
      eBytes = 0;
      return;
    end
    for (int n = 0; n <= int'((gl - g0) >> 4); n++) begin
      g   = g0 + 64'(n * 16);
      b   = tagMem[g[12:5]];
      nib = g[4] ? b[7:4] : b[3:0];
      if (nib != a[59:56]) begin
        ePass  = 1'b0;
        eFault = (n == 0) ? a : g;
        return;
      end
    end
  endfunction

  bit gotPass;
  logic [63:0] gotFault;
  int lat;

  task automatic runReq(input logic [63:0] a, input int sm1, input logic [1:0] tbi, input bit unt);
    while (!idle) @(negedge clk);
    rdCount      = 0;
    seqErr       = 0;
    reqAddr      = a;
    reqSizeM1    = SIZE_W'(sm1);
    tbiEnable    = tbi;
    untaggedPage = unt;
    reqValid     = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    gotPass  = pass;
    gotFault = faultAddr;
    chk(done == 1'b1, "R13 done seen", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R13 done single cycle", done, 0);
  endtask

  // Full check of one request against the reference model
  task automatic runAndCheck(input logic [63:0] a, input int sm1, input logic [1:0] tbi,
                             input bit unt, input string tag);
    bit ePass;
    logic [63:0] eFault;
    int eBytes;
    refModel(a, sm1, tbi, unt, ePass, eFault, eBytes);
    runReq(a, sm1, tbi, unt);
    chk(gotPass == ePass, {tag, " pass"}, gotPass, ePass);
    if (!ePass) chk(gotFault == eFault, {tag, " faultAddr"}, gotFault, eFault);
    if (eBytes == 0) begin
      chk(rdCount == 0, {tag, " no reads"}, rdCount, 0);
      chk(lat == 1, {tag, " bypass latency"}, lat, 1);
    end else begin
      chk(firstRd == RD_W'(a >> 5), "R4 first read address", firstRd, a >> 5);
      chk(seqErr == 0, "R4 consecutive addresses", seqErr, 0);
      if (ePass) begin
        chk(rdCount == eBytes, "R4 read count", rdCount, eBytes);
        chk(lat == eBytes + 2, "R13 latency", lat, eBytes + 2);
      end else begin
        chk(rdCount <= eBytes, "R4 read bound", rdCount, eBytes);
      end
    end
  endtask

  initial begin
    logic [63:0] a;
    void'($urandom(32'd20240611));
    fillTags(4'h5);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(idle == 1'b1, "R1 idle", idle, 1);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(tagRdEn == 1'b0, "R1 tagRdEn", tagRdEn, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(idle == 1'b1 && !tagRdEn, "R1 idle after release", idle, 1);

    // R2: enable picked by bit 55
    fillTags(4'h3);
    runAndCheck(mkAddr(4'h5, 1'b0, 13'h100), 31, 2'b10, 1'b0, "R2 low half disabled");
    runAndCheck(mkAddr(4'h5, 1'b1, 13'h100), 31, 2'b01, 1'b0, "R2 high half disabled");
    runAndCheck(mkAddr(4'h5, 1'b1, 13'h100), 31, 2'b10, 1'b0, "R2 high half enabled");
    chk(gotPass == 1'b0 && rdCount > 0, "R2 checked when enabled", rdCount, 1);

    // R3: page without tags
    runAndCheck(mkAddr(4'h5, 1'b0, 13'h200), 63, 2'b11, 1'b1, "R3 untagged");

    // R5: nibble order
    fillTags(4'h5);
    setNib(64'h0090, 4'h6);
    runAndCheck(mkAddr(4'h5, 1'b0, 13'h0080), 15, 2'b11, 1'b0, "R5 low nibble clean");
    chk(gotPass == 1'b1, "R5 low nibble for bit4=0", gotPass, 1);
    runAndCheck(mkAddr(4'h5, 1'b0, 13'h0094), 3, 2'b11, 1'b0, "R5 high nibble");
    chk(gotPass == 1'b0, "R5 high nibble for bit4=1", gotPass, 0);

    // R7: odd start skips low nibble of the first byte
    fillTags(4'h5);
    setNib(64'h0020, 4'h9);
    runAndCheck(mkAddr(4'h5, 1'b0, 13'h0038), 15, 2'b11, 1'b0, "R7 odd start");
    chk(gotPass == 1'b1 && rdCount == 2, "R7 odd start pass", rdCount, 2);

    // R6: partial last byte and tag count
    fillTags(4'h5);
    setNib(64'h0050, 4'h0);
    runAndCheck(mkAddr(4'h5, 1'b0, 13'h0040), 15, 2'b11, 1'b0, "R6 even end");
    chk(gotPass == 1'b1 && rdCount == 1, "R6 trailing nibble ignored", rdCount, 1);
    // R9: later granule fault at its base
    runAndCheck(mkAddr(4'h5, 1'b0, 13'h0040), 16, 2'b11, 1'b0, "R9 second granule");
    chk(gotFault == mkAddr(4'h5, 1'b0, 13'h0050), "R9 granule base", gotFault, mkAddr(4'h5, 1'b0, 13'h0050));

    // R8: first granule fault reports start address
    fillTags(4'h5);
    setNib(64'h0040, 4'h1);
    runAndCheck(mkAddr(4'h5, 1'b1, 13'h0047), 3, 2'b11, 1'b0, "R8 first granule");
    chk(gotFault == mkAddr(4'h5, 1'b1, 13'h0047), "R8 start address", gotFault, mkAddr(4'h5, 1'b1, 13'h0047));

    // R10: earliest of two mismatches
    fillTags(4'h5);
    setNib(64'h0160, 4'h2);
    setNib(64'h01A0, 4'h2);
    runAndCheck(mkAddr(4'h5, 1'b0, 13'h0108), 200, 2'b11, 1'b0, "R10 two mismatches");
    chk(gotFault == mkAddr(4'h5, 1'b0, 13'h0160), "R10 lowest granule", gotFault, mkAddr(4'h5, 1'b0, 13'h0160));

    // R12: logical tag from bits 59:56
    fillTags(4'hA);
    runAndCheck(mkAddr(4'hA, 1'b0, 13'h0300), 47, 2'b11, 1'b0, "R12 matching tag");
    chk(gotPass == 1'b1, "R12 tag A passes", gotPass, 1);
    runAndCheck(mkAddr(4'hB, 1'b0, 13'h0300), 47, 2'b11, 1'b0, "R12 other tag");
    chk(gotFault == mkAddr(4'hB, 1'b0, 13'h0300), "R12 tag B faults at start", gotFault, mkAddr(4'hB, 1'b0, 13'h0300));

    // R11: request while busy is ignored
    fillTags(4'h5);
    setNib(64'h0430, 4'h7);
    a = mkAddr(4'h5, 1'b0, 13'h0400);
    while (!idle) @(negedge clk);
    reqAddr = a; reqSizeM1 = SIZE_W'(255); tbiEnable = 2'b11; untaggedPage = 1'b0;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(idle == 1'b0, "R11 busy after accept", idle, 0);
    reqAddr = mkAddr(4'h5, 1'b0, 13'h0800); untaggedPage = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R11 no early result", done, 0);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
    chk(pass == 1'b0, "R11 first request result", pass, 0);
    chk(faultAddr == mkAddr(4'h5, 1'b0, 13'h0430), "R11 first request fault", faultAddr, mkAddr(4'h5, 1'b0, 13'h0430));
    untaggedPage = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done == 1'b0 && idle == 1'b1, "R11 no second result", done, 0);
    end

    // Random mix: R4 R6 R8 R9 R13 against the reference model
    for (int it = 0; it < 300; it++) begin
      logic [3:0] t;
      int sm1, off;
      bit pg, unt;
      logic [1:0] tbi;
      logic [63:0] g;
      t   = 4'($urandom % 16);
      fillTags(t);
      sm1 = int'($urandom % 160);
      off = int'($urandom % (4096 - sm1));
      pg  = 1'($urandom % 2);
      a   = mkAddr(t, 1'($urandom % 2), {pg, 12'(off)});
      tbi = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'b11;
      unt = ($urandom % 16 == 0);
      if ($urandom % 2 == 1) begin
        g = a + 64'($urandom % (sm1 + 1));
        setNib(g, t ^ 4'(1 + $urandom % 15));
      end
      if ($urandom % 4 == 0) begin
        g = a + 64'($urandom % (sm1 + 1));
        setNib(g, t ^ 4'(1 + $urandom % 15));
      end
      runAndCheck(a, sm1, tbi, unt, "R9 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule